// File: doc/BRIEF.md
# Serial Pattern Recognizer with Lockout

This block watches a one-bit serial stream, taking one bit on every rising clock edge. It raises its output when the three most recent bits, oldest first, are 0, 1, 0. It does this only while the sequence 1, 0, 0 has not occurred since the last reset. Matches may overlap, so the stream 0 1 0 1 0 gives two hits.

The first time 1, 0, 0 appears, the machine enters a locked state. It stays there, with the output low, until a synchronous reset returns it to its start state. The output is registered and follows a Moore discipline: it is high during the cycle after the edge that samples the bit completing 0, 1, 0.

A typical use is as a guard on a serial control line. A fixed marker is acknowledged only while a forbidden marker has never been sent.

Top module: `pr_recog_top`

## Requirements
- R1: While `rst` is high at a rising edge, the machine returns to its start state with no bits seen, and `z` reads 0 after that edge.
- R2: `z` is 1 after the edge that samples the bit completing 0, 1, 0 (oldest first) and 0 in every other cycle. It never rises before three bits have been sampled since reset.
- R3: Matches overlap. After a match, the bits 1 then 0 produce a second match, so 0 1 0 1 0 gives `z` = 1 after the third and the fifth bit.
- R4: Once 1, 0, 0 has been sampled, `z` stays 0 for every later bit until reset, whatever the input.
- R5: A reset issued while locked clears the lockout, and a later 0, 1, 0 raises `z` again.
- R6: Bit orders that are not 0, 1, 0 (for example 0 1 1 0, or 1 1 1) keep `z` at 0.
- R7: The lockout is caused by 1, 0, 0 wherever it appears, including before any match (1 1 0 0) and right after a match (0 1 0 0).
- R8: Leading runs of zeros or of ones do not prevent detection: 0 0 0 0 1 0 and 1 1 1 1 0 1 0 both end with `z` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one serial bit is sampled per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x | input | 1 | Serial data bit |
| z | output | 1 | Registered match flag |

## Verification
Most state faults reach `z` within one to three bits:
- A wrong transition out of a suffix state shows up as a missing or an extra pulse on the next 0 or 1 that should close or break a match.
- A trap state that leaks turns up as a pulse after a later 1, 0 pair.
- A start state that wrongly remembers a bit gives a pulse after only two bits.

The bench drives streams chosen to place each transition right before the edge where `z` would differ. It compares `z` every cycle against a model that keeps only the bit history and a lockout flag.

// File: rtl/pr_pkg.sv
package pr_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_START  = 3'd0,
        ST_SEEN0  = 3'd1,
        ST_SEEN1  = 3'd2,
        ST_SUF01  = 3'd3,
        ST_SUF10  = 3'd4,
        ST_MATCH  = 3'd5,
        ST_LOCKED = 3'd6
    } pr_state_e;

    typedef struct packed {
        pr_state_e state;
        logic      hit;
    } pr_step_t;

    function automatic pr_state_e pr_advance(input pr_state_e cur, input logic bit_in);
        pr_state_e nxt;
        case (cur)
            ST_START:  nxt = bit_in ? ST_SEEN1 : ST_SEEN0;
            ST_SEEN0:  nxt = bit_in ? ST_SUF01 : ST_SEEN0;
            ST_SEEN1:  nxt = bit_in ? ST_SEEN1 : ST_SUF10;
            ST_SUF01:  nxt = bit_in ? ST_SEEN1 : ST_MATCH;
            ST_SUF10:  nxt = bit_in ? ST_SUF01 : ST_LOCKED;
            ST_MATCH:  nxt = bit_in ? ST_SUF01 : ST_LOCKED;
            ST_LOCKED: nxt = ST_LOCKED;
            default:   nxt = ST_START;
        endcase
        return nxt;
    endfunction

    function automatic logic pr_is_hit(input pr_state_e s);
        return (s == ST_MATCH);
    endfunction

endpackage

// File: rtl/pr_next_state.sv
module pr_next_state
    import pr_pkg::*;
(
    input  pr_state_e cur_state,
    input  logic      bit_in,
    output pr_state_e nxt_state
);
    always_comb begin
        nxt_state = pr_advance(cur_state, bit_in);
    end
endmodule

// File: rtl/pr_out_decode.sv
module pr_out_decode
    import pr_pkg::*;
(
    input  pr_state_e nxt_state,
    output pr_step_t  step
);
    always_comb begin
        step.state = nxt_state;
        step.hit   = pr_is_hit(nxt_state);
    end
endmodule

// File: rtl/pr_state_reg.sv
module pr_state_reg
    import pr_pkg::*;
#(
    parameter pr_state_e RESET_STATE = ST_START
) (
    input  logic      clk,
    input  logic      rst,
    input  pr_step_t  step,
    output pr_state_e state_q,
    output logic      hit_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RESET_STATE;
            hit_q   <= 1'b0;
        end else begin
            state_q <= step.state;
            hit_q   <= step.hit;
        end
    end

    AST_RESET_START: assert property (@(posedge clk) rst |=> (state_q == RESET_STATE) && !hit_q); // R1
endmodule

// File: rtl/pr_recog_top.sv
module pr_recog_top
    import pr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x,
    output logic z
);
    pr_state_e cur_state;
    pr_state_e nxt_state;
    pr_step_t  step;
    logic      hit_q;

    pr_next_state u_nsl (
        .cur_state (cur_state),
        .bit_in    (x),
        .nxt_state (nxt_state)
    );

    pr_out_decode u_dec (
        .nxt_state (nxt_state),
        .step      (step)
    );

    pr_state_reg #(.RESET_STATE(ST_START)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .state_q (cur_state),
        .hit_q   (hit_q)
    );

    assign z = hit_q;

    AST_HIT_AFTER_SUF01: assert property (@(posedge clk) disable iff (rst)
        z |-> (!$past(x) && $past(cur_state) == ST_SUF01)); // R2
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_LOCKED) |=> (cur_state == ST_LOCKED) && !z); // R4
    AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (cur_state != ST_LOCKED) ##1 (cur_state == ST_LOCKED) |-> !$past(x)); // R7
    AST_HIT_MEANS_MATCH: assert property (@(posedge clk) disable iff (rst)
        z |-> (cur_state == ST_MATCH)); // R2
endmodule

// File: tb/sim_pr_recog_top.sv
module sim_pr_recog_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x   = 1'b0;
    logic z;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    item_t q[$];

    logic [2:0] hist = 3'b000;
    int         nbits = 0;
    bit         locked = 0;

    pr_recog_top u0 (.clk(clk), .rst(rst), .x(x), .z(z));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic do_reset(input string tag);
        item_t it;
        @(negedge clk);
        rst = 1'b1;
        hist = 3'b000; nbits = 0; locked = 0;
        it.exp = 1'b0; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic send_bit(input logic b, input string tag);
        item_t it;
        @(negedge clk);
        rst = 1'b0;
        x = b;
        hist = {hist[1:0], b};
        nbits++;
        if (nbits >= 3 && hist == 3'b100) locked = 1;
        it.exp = (!locked && nbits >= 3 && hist == 3'b010);
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic send_str(input string s, input string tag);
        for (int i = 0; i < s.len(); i++) send_bit(s[i] == "1", tag);
    endtask

    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            vectors++;
            if (z !== it.exp) begin
                miscompares++;
                $display("FAIL %s: z=%b expected=%b at %0t", it.tag, z, it.exp, $time);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        do_reset("R1");
        do_reset("R1");
        send_str("010", "R2");
        send_str("10", "R3");
        send_str("10", "R3");
        send_str("0", "R7");
        send_str("10101", "R4");
        do_reset("R5");
        send_str("010", "R5");
        do_reset("R1");
        send_str("0010101001", "R4");
        send_str("0", "R4");
        do_reset("R6");
        send_str("0110", "R6");
        send_str("111", "R6");
        do_reset("R7");
        send_str("1100", "R7");
        send_str("10", "R7");
        do_reset("R8");
        send_str("000010", "R8");
        do_reset("R8");
        send_str("1111010", "R8");
        do_reset("R2");
        send_str("10", "R2");
        send_str("1011010", "R3");
        send_bit(1'b1, "R1");
        do_reset("R1");
        @(posedge clk);
        #2;
        @(posedge clk);
        #2;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule